// File: doc/BRIEF.md
# Ingress Data Sync and Parity Monitor

This block watches the receive side of a packet data path that uses periodic training patterns and four-bit diagonal parity. It gets three single-cycle event pulses from the upstream word-alignment and parity logic: a complete training pattern has been seen, a non-training word has been seen, and a parity error has been seen. Parity errors are counted in a 16-bit counter that saturates and clears when read. Runs of back-to-back training patterns are counted as well. A run that reaches a programmable threshold raises a loss-of-synchronisation flag.

Software reaches the block through a small register port. Address 0 returns the parity error count and clears it. Address 1 holds the 8-bit run threshold, which can be read and written. A threshold of zero turns the synchronisation check off. All outputs are registered.

Top module: `ingress_sync_monitor`

## Requirements
- R1: After a synchronous active-high reset, `oos_o` is 0, `reg_rdata_o` is 0, the error count is 0 and the threshold is 0.
- R2: Each cycle with `par_err_i` high adds one to the error count. A read strobe at address 0 returns the count on `reg_rdata_o` in the next cycle.
- R3: The error count stops at 0xFFFF and never wraps to zero while errors continue.
- R4: A read at address 0 clears the count. It holds the value seen before the read, and counting then starts again from zero.
- R5: If a read at address 0 and an error pulse fall in the same cycle, the count becomes 1 after the read, so the error is kept.
- R6: Address 1 holds an 8-bit threshold that can be written and read back, zero-extended, one cycle after the read strobe. Writes to address 0 have no effect. Reads of any other address return 0.
- R7: While the threshold is 0, `oos_o` stays low whatever training activity occurs. Writing 0 while `oos_o` is high drops it one cycle later.
- R8: With threshold N > 0, `oos_o` rises in the cycle after the N-th consecutive training pulse.
- R9: A non-training word pulse sets the run count to zero and drops `oos_o` in the next cycle. When it arrives in the same cycle as a training pulse, the non-training word wins.
- R10: `reg_rdata_o` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_i | input | 1 | One complete training pattern received |
| data_word_i | input | 1 | One non-training word received |
| par_err_i | input | 1 | Parity error detected on one word |
| reg_addr_i | input | ADDR_W | Register address (0 count, 1 threshold) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | THR_W | Write data |
| reg_rdata_o | output | CNT_W | Read data, valid the cycle after a read |
| oos_o | output | 1 | Out-of-synchronisation flag |

## Verification
A wrong run count shows up on `oos_o` one cycle early or one cycle late relative to the N-th training pulse. A run count that is not cleared by a non-training word makes `oos_o` rise too soon on the next burst. A corrupted error count stays invisible until the next read at address 0, so the reference model compares `reg_rdata_o` after every read and checks that it holds between reads. The saturation and same-cycle read/error cases are driven on purpose, because a lost or wrapped count would otherwise go unseen.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;
  localparam int unsigned ADDR_ERRCNT = 0;
  localparam int unsigned ADDR_THRESH = 1;
endpackage

// File: rtl/sync_mon_errcnt.sv
module sync_mon_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= err_i ? CNT_ONE : '0;
    end else if (err_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX); // R3
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !err_i) |=> cnt_q == '0); // R4
  AST_CLR_KEEPS_ERR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && err_i) |=> cnt_q == CNT_ONE); // R5
endmodule

// File: rtl/sync_mon_trainrun.sv
module sync_mon_trainrun #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             train_i,
  input  logic             data_word_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             oos_o
);
  localparam logic [THR_W-1:0] RUN_MAX = '1;

  logic [THR_W-1:0] run_q;
  logic [THR_W-1:0] run_inc;
  logic             oos_q;

  always_comb begin
    run_inc = (run_q == RUN_MAX) ? run_q : run_q + THR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      oos_q <= 1'b0;
    end else begin
      if (data_word_i) begin
        run_q <= '0;
      end else if (train_i) begin
        run_q <= run_inc;
      end
      if (thr_i == '0 || data_word_i) begin
        oos_q <= 1'b0;
      end else if (train_i && run_inc >= thr_i) begin
        oos_q <= 1'b1;
      end
    end
  end

  assign oos_o = oos_q;

  AST_OOS_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (thr_i == '0) |=> !oos_q); // R7
  AST_OOS_DROP_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    data_word_i |=> !oos_q); // R9
  AST_OOS_RISE_ON_TRAIN: assert property (@(posedge clk) disable iff (rst)
    $rose(oos_q) |-> $past(train_i)); // R8
endmodule

// File: rtl/sync_mon_regs.sv
module sync_mon_regs #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 16,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [THR_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              cnt_clr_o,
  output logic [THR_W-1:0]  thr_o,
  output logic [CNT_W-1:0]  rdata_o
);
  import sync_mon_pkg::*;

  logic             sel_cnt;
  logic             sel_thr;
  logic [THR_W-1:0] thr_q;
  logic [CNT_W-1:0] rdata_q;
  logic [CNT_W-1:0] rd_mux;

  assign sel_cnt = (addr_i == ADDR_W'(ADDR_ERRCNT));
  assign sel_thr = (addr_i == ADDR_W'(ADDR_THRESH));

  always_comb begin
    if (sel_cnt)      rd_mux = cnt_i;
    else if (sel_thr) rd_mux = CNT_W'(thr_q);
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && sel_thr) thr_q <= wdata_i;
      if (rd_i)            rdata_q <= rd_mux;
    end
  end

  assign cnt_clr_o = rd_i && sel_cnt;
  assign thr_o     = thr_q;
  assign rdata_o   = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q)); // R10
  AST_THR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_thr) |=> thr_q == $past(wdata_i)); // R6
endmodule

// File: rtl/ingress_sync_monitor.sv
module ingress_sync_monitor #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 16,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              train_i,
  input  logic              data_word_i,
  input  logic              par_err_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [THR_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              oos_o
);
  logic [CNT_W-1:0] err_cnt;
  logic             cnt_clr;
  logic [THR_W-1:0] thr;

  sync_mon_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .rd_i(reg_rd_i), .wdata_i(reg_wdata_i), .cnt_i(err_cnt),
    .cnt_clr_o(cnt_clr), .thr_o(thr), .rdata_o(reg_rdata_o)
  );

  sync_mon_errcnt #(.CNT_W(CNT_W)) u_errcnt (
    .clk(clk), .rst(rst), .err_i(par_err_i), .clr_i(cnt_clr), .cnt_o(err_cnt)
  );

  sync_mon_trainrun #(.THR_W(THR_W)) u_trainrun (
    .clk(clk), .rst(rst), .train_i(train_i), .data_word_i(data_word_i),
    .thr_i(thr), .oos_o(oos_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!oos_o && reg_rdata_o == '0)); // R1
endmodule

// File: tb/ingress_sync_monitor_bench.sv
module ingress_sync_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        train_i = 0, data_word_i = 0, par_err_i = 0;
  logic [1:0]  reg_addr_i = 0;
  logic        reg_wr_i = 0, reg_rd_i = 0;
  logic [7:0]  reg_wdata_i = 0;
  logic [15:0] reg_rdata_o;
  logic        oos_o;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_thr = 0, m_run = 0, m_oos = 0, m_rdata = 0;
  string req = "R1";

  always #10 clk = ~clk;

  ingress_sync_monitor u_ingress_sync_monitor (
    .clk(clk), .rst(rst), .train_i(train_i), .data_word_i(data_word_i),
    .par_err_i(par_err_i), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .oos_o(oos_o)
  );

  task automatic check(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(req, int'(oos_o), m_oos, "oos_o");
    check(req, int'(reg_rdata_o), m_rdata, "reg_rdata_o");
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input bit tr, input bit dw, input bit er,
                     input bit wr, input bit rd, input int addr, input int wd);
    int thr_new;
    train_i = tr; data_word_i = dw; par_err_i = er;
    reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = 2'(addr); reg_wdata_i = 8'(wd);
    @(posedge clk);
    thr_new = m_thr;
    if (rd && addr == 0) begin
      m_rdata = m_cnt;
      m_cnt = er ? 1 : 0;
    end else begin
      if (er && m_cnt < 65535) m_cnt++;
      if (rd) m_rdata = (addr == 1) ? m_thr : 0;
    end
    if (wr && addr == 1) thr_new = wd & 255;
    if (dw) m_run = 0;
    else if (tr && m_run < 255) m_run++;
    if (m_thr == 0 || dw) m_oos = 0;
    else if (tr && m_run >= m_thr) m_oos = 1;
    m_thr = thr_new;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0); endtask
  task automatic rd_reg(int a); cyc(0,0,0,0,1,a,0); endtask
  task automatic wr_thr(int v); cyc(0,0,0,1,0,1,v); endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    req = "R1"; compare_all();
    rd_reg(0); check("R1", int'(reg_rdata_o), 0, "count after reset");
    rd_reg(1); check("R1", int'(reg_rdata_o), 0, "threshold after reset");

    req = "R2";
    for (int i = 0; i < 5; i++) cyc(0,0,1,0,0,0,0);
    idle(); idle();
    rd_reg(0); check("R2", int'(reg_rdata_o), 5, "count of five errors");
    req = "R4";
    rd_reg(0); check("R4", int'(reg_rdata_o), 0, "count after clear");
    req = "R10"; idle(); idle();
    check("R10", int'(reg_rdata_o), 0, "rdata held");

    req = "R5";
    cyc(0,0,1,0,0,0,0); cyc(0,0,1,0,0,0,0);
    cyc(0,0,1,0,1,0,0); check("R5", int'(reg_rdata_o), 2, "read with error");
    rd_reg(0); check("R5", int'(reg_rdata_o), 1, "error kept after clear");

    req = "R3";
    for (int i = 0; i < 65540; i++) cyc(0,0,1,0,0,0,0);
    rd_reg(0); check("R3", int'(reg_rdata_o), 65535, "saturated count");
    rd_reg(0); check("R3", int'(reg_rdata_o), 0, "cleared after saturation");

    req = "R6";
    wr_thr(8'hA5); rd_reg(1); check("R6", int'(reg_rdata_o), 165, "threshold readback");
    cyc(0,0,0,1,0,0,8'h33); rd_reg(0); check("R6", int'(reg_rdata_o), 0, "write to count ignored");
    rd_reg(1); check("R6", int'(reg_rdata_o), 165, "threshold unchanged");
    rd_reg(2); check("R6", int'(reg_rdata_o), 0, "unused address");

    req = "R8";
    wr_thr(3);
    cyc(1,0,0,0,0,0,0); cyc(1,0,0,0,0,0,0);
    check("R8", int'(oos_o), 0, "two trains below threshold");
    cyc(1,0,0,0,0,0,0); check("R8", int'(oos_o), 1, "third train");
    req = "R9";
    cyc(1,0,0,0,0,0,0); cyc(0,1,0,0,0,0,0); check("R9", int'(oos_o), 0, "data word clears");
    cyc(1,0,0,0,0,0,0); cyc(1,0,0,0,0,0,0); cyc(1,1,0,0,0,0,0);
    check("R9", int'(oos_o), 0, "data wins over train");
    cyc(1,0,0,0,0,0,0); cyc(1,0,0,0,0,0,0);
    check("R9", int'(oos_o), 0, "run restarted");
    cyc(1,0,0,0,0,0,0); check("R9", int'(oos_o), 1, "third train after restart");

    req = "R7";
    wr_thr(0); idle(); check("R7", int'(oos_o), 0, "zero threshold drops flag");
    for (int i = 0; i < 300; i++) cyc(1,0,0,0,0,0,0);
    check("R7", int'(oos_o), 0, "disabled under long run");
    wr_thr(1); cyc(1,0,0,0,0,0,0); check("R7", int'(oos_o), 1, "re-enabled with saturated run");
    cyc(0,1,0,0,0,0,0); cyc(1,0,0,0,0,0,0);
    check("R8", int'(oos_o), 1, "threshold one");

    req = "R1";
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_cnt = 0; m_thr = 0; m_run = 0; m_oos = 0; m_rdata = 0;
    compare_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule